// File: doc/BRIEF.md
# Two-Channel Timed Pulse Train Generator

This block drives pulse trains on two output pins. The pulses line up with an externally supplied local time, given as 32-bit seconds and 30-bit nanoseconds. Each of two event channels holds a target time and a reload period. When local time is equal to or later than the target, the channel starts a pulse. The pulse lasts for a width picked from a fixed table of durations. Unless the channel is set to single-shot, its target then moves forward by one period, so the output repeats.

Software programs the block through a 16-bit write-only word interface. One word holds the per-channel width code, the single-shot bit and the polarity bit. Each channel's target and period are each written as four 16-bit words. A further word controls the two pins: it picks event output or plain GPIO level, and it sets the direction and the buffer type of each pin. A channel is switched off by moving its target out to 0xFFFFFFFF seconds. The time counter itself lives outside the block.

Top module: `pulse_train_gen`

## Requirements
- R1: After synchronous reset both pins are in plain GPIO mode with level 0, pin_o = 0, pin_oe = 0 and pin_pp = 0, and both targets sit at 0xFFFFFFFF s, 0 ns.
- R2: A channel matches when local time is equal to or later than its target. Its pulse is active from the clock edge that samples the matching time.
- R3: When the channel's single-shot bit is 0, each match adds the reload period to the target, so pulses repeat every period.
- R4: Adding the period carries into seconds whenever the nanosecond sum reaches 1,000,000,000.
- R5: The pulse ends at the first edge whose sampled time is at or after match target + width. The width code maps as 0=100 ns, 1=500 ns, 2=1 µs, 3=5 µs, 4=10 µs, 5=50 µs, 6=100 µs, 7=500 µs, 8=1 ms, 9=5 ms, 10=10 ms, 11=50 ms, 12=100 ms, 13=200 ms, and codes 14 and 15 give 100 ns.
- R6: The configuration word is at address 0x00. Channel A uses bits 7:4 for its width code, bit 0 for single-shot and bit 1 for polarity. Channel B uses bits 11:8 for its width code, bit 2 for single-shot and bit 3 for polarity.
- R7: With the polarity bit at 1 a pulse drives the event level high, otherwise low. When no pulse is active the event level is the inverse.
- R8: With the single-shot bit at 1 a match fires one pulse and the channel then stays idle until one of its target words is written again.
- R9: A target of 0xFFFFFFFF s, 0 ns produces no pulse for any local time below it.
- R10: Channel A words are at 0x10 to 0x17 and channel B words at 0x18 to 0x1F. Word offsets are 0 target seconds high, 1 target seconds low, 2 target nanoseconds high, 3 target nanoseconds low, and 4 to 7 the same fields of the period. Only bits 13:0 of a nanoseconds-high word are kept.
- R11: Any write to the configuration word ends a pulse in progress on both channels, and any write to a channel's words ends that channel's pulse, from the write edge on.
- R12: The pin word is at 0x01, with bits 1:0 GPIO select, 3:2 direction, 5:4 push-pull and 7:6 GPIO level. Pin i carries only channel i (0=A, 1=B). When its select bit is 1 the pin drives its level bit instead of the event. pin_oe follows the direction bit and pin_pp follows the push-pull bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_sec | input | 32 | Local time, seconds |
| now_ns | input | 30 | Local time, nanoseconds (below 1e9) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register word address |
| wr_data | input | 16 | Register write data |
| pin_o | output | 2 | Pin output levels |
| pin_oe | output | 2 | Pin output enables (direction) |
| pin_pp | output | 2 | Pin buffer type, 1 = push-pull |

## Verification
The bench sets the local time exactly at the target and one nanosecond before it. A design that compares with strictly-greater would then start its pulse late. It places a target 100 ns before a second boundary with a 300 ns period: a missing carry would make the second pulse come a whole second early or never. The bench also checks that the pulse ends exactly at target + width for the 200 ms code and for the reserved codes, that a single-shot channel does not fire a second time, and that a register write cuts a live pulse. Random trials with a fixed seed set both channels at once with different widths, periods and polarities, so a swapped configuration field or a pin wired to the wrong channel shows up as a level mismatch.

// File: rtl/ptg_pkg.sv
// Package: shared widths, time type and helper functions for the pulse
// train generator. Assumes nanoseconds stay below one second.
package ptg_pkg;
    localparam int WORD_W  = 16;
    localparam int SEC_W   = 2 * WORD_W;
    localparam int NS_W    = 30;
    localparam int NUM_CH  = 2;
    localparam int CODE_W  = 4;
    localparam int CFG_W   = 4 + CODE_W * NUM_CH;
    localparam int PIN_W   = 4 * NUM_CH;
    localparam logic [NS_W:0] NS_PER_SEC = 31'd1_000_000_000;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tstamp_t;

    // Pulse width in nanoseconds for a width code; reserved codes give 100 ns.
    function automatic logic [NS_W-1:0] width_ns(input logic [CODE_W-1:0] code);
        logic [NS_W-1:0] w;
        case (code)
            4'd0:    w = 30'd100;
            4'd1:    w = 30'd500;
            4'd2:    w = 30'd1_000;
            4'd3:    w = 30'd5_000;
            4'd4:    w = 30'd10_000;
            4'd5:    w = 30'd50_000;
            4'd6:    w = 30'd100_000;
            4'd7:    w = 30'd500_000;
            4'd8:    w = 30'd1_000_000;
            4'd9:    w = 30'd5_000_000;
            4'd10:   w = 30'd10_000_000;
            4'd11:   w = 30'd50_000_000;
            4'd12:   w = 30'd100_000_000;
            4'd13:   w = 30'd200_000_000;
            default: w = 30'd100;
        endcase
        return w;
    endfunction

    // Add a seconds/nanoseconds offset to a time, carrying into seconds.
    function automatic tstamp_t tadd(input tstamp_t a, input logic [SEC_W-1:0] ds,
                                     input logic [NS_W-1:0] dn);
        tstamp_t r;
        logic [NS_W:0] s;
        s = {1'b0, a.ns} + {1'b0, dn};
        if (s >= NS_PER_SEC) begin
            r.ns  = NS_W'(s - NS_PER_SEC);
            r.sec = a.sec + ds + 1'b1;
        end else begin
            r.ns  = s[NS_W-1:0];
            r.sec = a.sec + ds;
        end
        return r;
    endfunction
endpackage

// File: rtl/ptg_regs.sv
// Register block: holds the configuration and pin words and decodes
// channel word writes. Assumes one write per cycle; registers are write-only.
module ptg_regs
    import ptg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CFG_W-1:0]               wr_data,
    output logic                           cfg_wr,
    output logic [NUM_CH-1:0]              ch_wr,
    output logic [2:0]                     ch_word,
    output logic [NUM_CH-1:0][CODE_W-1:0]  width_code,
    output logic [NUM_CH-1:0]              one_shot,
    output logic [NUM_CH-1:0]              pol,
    output logic [NUM_CH-1:0]              pin_sel,
    output logic [NUM_CH-1:0]              pin_dir,
    output logic [NUM_CH-1:0]              pin_buf,
    output logic [NUM_CH-1:0]              pin_lvl
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(8'h01);

    logic [CFG_W-1:0] cfg_q;
    logic [PIN_W-1:0] pin_q;
    logic             pin_wr;
    logic             ch_range;

    // Address decode for the two words and the channel windows.
    assign cfg_wr   = wr_en && (wr_addr == CFG_ADDR);
    assign pin_wr   = wr_en && (wr_addr == PIN_ADDR);
    assign ch_range = (wr_addr[ADDR_W-1:4] == (ADDR_W-4)'(1));
    assign ch_word  = wr_addr[2:0];

    // Storage of the configuration and pin words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            pin_q <= PIN_W'({NUM_CH{1'b1}});
        end else begin
            if (cfg_wr) cfg_q <= wr_data;
            if (pin_wr) pin_q <= wr_data[PIN_W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_wr[c]      = wr_en && ch_range && (wr_addr[3] == 1'(c));
        assign width_code[c] = cfg_q[4 + CODE_W*c +: CODE_W];
        assign one_shot[c]   = cfg_q[2*c];
        assign pol[c]        = cfg_q[2*c + 1];
        assign pin_sel[c]    = pin_q[c];
        assign pin_dir[c]    = pin_q[NUM_CH + c];
        assign pin_buf[c]    = pin_q[2*NUM_CH + c];
        assign pin_lvl[c]    = pin_q[3*NUM_CH + c];
    end
endmodule

// File: rtl/ptg_channel.sv
// Event channel: compares local time with the target, starts a pulse of the
// coded width and reloads or disarms. Assumes programmed ns fields < 1e9.
module ptg_channel
    import ptg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tstamp_t           now,
    input  logic              wr_en,
    input  logic [2:0]        wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] width_code,
    input  logic              one_shot,
    output logic              active,
    output logic              fire,
    output logic              armed,
    output tstamp_t           target,
    output tstamp_t           end_time
);
    localparam int NSH_W = NS_W - WORD_W;

    tstamp_t period;

    // Match: armed and local time at or past the target.
    assign fire = armed && (now >= target);

    // Target/period storage, pulse start, pulse end and reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target.sec <= '1;
            target.ns  <= '0;
            period     <= '0;
            end_time   <= '0;
            armed      <= 1'b1;
            active     <= 1'b0;
        end else if (wr_en) begin
            active <= 1'b0;
            if (!wr_word[2]) armed <= 1'b1;
            case (wr_word)
                3'd0: target.sec[SEC_W-1:WORD_W] <= wr_data;
                3'd1: target.sec[WORD_W-1:0]     <= wr_data;
                3'd2: target.ns[NS_W-1:WORD_W]   <= wr_data[NSH_W-1:0];
                3'd3: target.ns[WORD_W-1:0]      <= wr_data;
                3'd4: period.sec[SEC_W-1:WORD_W] <= wr_data;
                3'd5: period.sec[WORD_W-1:0]     <= wr_data;
                3'd6: period.ns[NS_W-1:WORD_W]   <= wr_data[NSH_W-1:0];
                default: period.ns[WORD_W-1:0]   <= wr_data;
            endcase
        end else if (cfg_wr) begin
            active <= 1'b0;
        end else if (fire) begin
            active   <= 1'b1;
            end_time <= tadd(target, '0, width_ns(width_code));
            if (one_shot) armed  <= 1'b0;
            else          target <= tadd(target, period.sec, period.ns);
        end else if (active && (now >= end_time)) begin
            active <= 1'b0;
        end
    end
endmodule

// File: rtl/ptg_pinmux.sv
// Pin mux: applies polarity to each channel and selects event or GPIO level
// per pin. Assumes pin i is tied to channel i.
module ptg_pinmux
    import ptg_pkg::*;
(
    input  logic [NUM_CH-1:0] active,
    input  logic [NUM_CH-1:0] pol,
    input  logic [NUM_CH-1:0] pin_sel,
    input  logic [NUM_CH-1:0] pin_dir,
    input  logic [NUM_CH-1:0] pin_buf,
    input  logic [NUM_CH-1:0] pin_lvl,
    output logic [NUM_CH-1:0] pin_o,
    output logic [NUM_CH-1:0] pin_oe,
    output logic [NUM_CH-1:0] pin_pp
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
        logic ev_lvl;
        // Event level with polarity applied.
        assign ev_lvl    = pol[i] ? active[i] : ~active[i];
        assign pin_o[i]  = pin_sel[i] ? pin_lvl[i] : ev_lvl;
        assign pin_oe[i] = pin_dir[i];
        assign pin_pp[i] = pin_buf[i];
    end
endmodule

// File: rtl/pulse_train_gen.sv
// Top: two event channels, register block and pin mux. Local time comes
// from outside; the block only compares against it.
module pulse_train_gen
    import ptg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [NS_W-1:0]   now_ns,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pin_o,
    output logic [NUM_CH-1:0] pin_oe,
    output logic [NUM_CH-1:0] pin_pp
);
    tstamp_t                          now;
    logic                             cfg_wr;
    logic [NUM_CH-1:0]                ch_wr;
    logic [2:0]                       ch_word;
    logic [NUM_CH-1:0][CODE_W-1:0]    width_code;
    logic [NUM_CH-1:0]                one_shot, pol;
    logic [NUM_CH-1:0]                pin_sel, pin_dir, pin_buf, pin_lvl;
    logic [NUM_CH-1:0]                ch_active, ch_fire, ch_armed;
    tstamp_t [NUM_CH-1:0]             ch_target, ch_end;

    assign now.sec = now_sec;
    assign now.ns  = now_ns;

    ptg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data[CFG_W-1:0]), .cfg_wr(cfg_wr), .ch_wr(ch_wr),
        .ch_word(ch_word), .width_code(width_code), .one_shot(one_shot),
        .pol(pol), .pin_sel(pin_sel), .pin_dir(pin_dir), .pin_buf(pin_buf),
        .pin_lvl(pin_lvl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ptg_channel u_chan (
            .clk(clk), .rst_n(rst_n), .now(now), .wr_en(ch_wr[c]),
            .wr_word(ch_word), .wr_data(wr_data), .cfg_wr(cfg_wr),
            .width_code(width_code[c]), .one_shot(one_shot[c]),
            .active(ch_active[c]), .fire(ch_fire[c]), .armed(ch_armed[c]),
            .target(ch_target[c]), .end_time(ch_end[c])
        );
    end

    ptg_pinmux u_pinmux (
        .active(ch_active), .pol(pol), .pin_sel(pin_sel), .pin_dir(pin_dir),
        .pin_buf(pin_buf), .pin_lvl(pin_lvl), .pin_o(pin_o), .pin_oe(pin_oe),
        .pin_pp(pin_pp)
    );
endmodule

// File: rtl/ptg_chk.sv
// Checker: temporal properties of the channels, bound to the top module.
module ptg_chk
    import ptg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [SEC_W-1:0]     now_sec,
    input logic [NS_W-1:0]      now_ns,
    input logic                 cfg_wr,
    input logic [NUM_CH-1:0]    ch_wr,
    input logic [NUM_CH-1:0]    one_shot,
    input logic [NUM_CH-1:0]    ch_active,
    input logic [NUM_CH-1:0]    ch_fire,
    input logic [NUM_CH-1:0]    ch_armed,
    input tstamp_t [NUM_CH-1:0] ch_target,
    input tstamp_t [NUM_CH-1:0] ch_end
);
    tstamp_t now_t;
    assign now_t.sec = now_sec;
    assign now_t.ns  = now_ns;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_active[c]) |-> $past(now_t >= ch_target[c]));

        p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_fire[c] && !one_shot[c] && !ch_wr[c] && !cfg_wr)
            |=> (ch_target[c] >= $past(ch_target[c])));

        p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(ch_active[c]) && !$past(cfg_wr) && !$past(ch_wr[c]))
            |-> $past(now_t >= ch_end[c]));

        p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_fire[c] && one_shot[c] && !ch_wr[c] && !cfg_wr) |=> !ch_armed[c]);

        p_cut_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr || ch_wr[c]) |=> !ch_active[c]);
    end
endmodule

bind pulse_train_gen ptg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
    .cfg_wr(cfg_wr), .ch_wr(ch_wr), .one_shot(one_shot),
    .ch_active(ch_active), .ch_fire(ch_fire), .ch_armed(ch_armed),
    .ch_target(ch_target), .ch_end(ch_end)
);

// File: tb/pulse_train_gen_test.sv
module pulse_train_gen_test;
    localparam longint NSPS = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] now_sec = '0;
    logic [29:0] now_ns = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pin_o, pin_oe, pin_pp;

    int n_vec = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pulse_train_gen uut (
        .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_o(pin_o), .pin_oe(pin_oe), .pin_pp(pin_pp)
    );

    function automatic longint w_of(input int code);
        case (code)
            0: return 100;        1: return 500;        2: return 1000;
            3: return 5000;       4: return 10000;      5: return 50000;
            6: return 100000;     7: return 500000;     8: return 1000000;
            9: return 5000000;    10: return 10000000;  11: return 50000000;
            12: return 100000000; 13: return 200000000;
            default: return 100;
        endcase
    endfunction

    function automatic bit exp_act(input longint t, input longint s,
                                   input longint p, input longint w);
        if (t < s) return 1'b0;
        return ((t - s) % p) < w;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input longint t);
        now_sec = 32'(t / NSPS);
        now_ns  = 30'(t % NSPS);
        @(negedge clk);
    endtask

    // Program a channel's target and period with local time parked at zero.
    task automatic prog(input int c, input longint tgt, input longint per,
                        input logic [15:0] junk);
        logic [7:0]  b;
        logic [31:0] ts, ps;
        logic [29:0] tn, pn;
        b  = 8'h10 + 8'(8 * c);
        ts = 32'(tgt / NSPS); tn = 30'(tgt % NSPS);
        ps = 32'(per / NSPS); pn = 30'(per % NSPS);
        tick(0);
        wr(b + 8'd1, ts[15:0]);  wr(b + 8'd0, ts[31:16]);
        wr(b + 8'd3, tn[15:0]);  wr(b + 8'd2, {2'b00, tn[29:16]} | junk);
        wr(b + 8'd5, ps[15:0]);  wr(b + 8'd4, ps[31:16]);
        wr(b + 8'd7, pn[15:0]);  wr(b + 8'd6, {2'b00, pn[29:16]} | junk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        int seed;
        longint base;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of the pins; parked targets never fire
        chk("R1 pin_o", pin_o, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_pp", pin_pp, 0);

        // R12: event select, output enable and push-pull
        wr(8'h01, 16'h003C);
        chk("R12 pin_oe", pin_oe, 3);
        chk("R12 pin_pp", pin_pp, 3);
        // R7: polarity 0, idle level is high
        chk("R7 idle high", pin_o, 3);
        tick(64'd4_294_967_294 * NSPS + 64'd999_999_999);
        chk("R1 parked reset target", pin_o, 3);

        // R12: GPIO select drives the level bits
        wr(8'h01, 16'h00BF);
        chk("R12 gpio level", pin_o, 2);
        wr(8'h01, 16'h003C);

        // R2/R4/R10: equality match and carry into seconds, junk in ns-high
        wr(8'h00, 16'h0002);
        base = 64'd7 * NSPS;
        prog(0, base + 64'd999_999_900, 64'd300, 16'hC000);
        tick(base + 64'd999_999_899);
        chk("R2 before target", pin_o, 2);
        tick(base + 64'd999_999_900);
        chk("R2 equal target", pin_o, 3);
        tick(base + 64'd999_999_950);
        chk("R5 within width", pin_o, 3);
        tick(base + NSPS);
        chk("R5 end at width", pin_o, 2);
        tick(base + NSPS + 64'd199);
        chk("R4 carry before", pin_o, 2);
        tick(base + NSPS + 64'd200);
        chk("R4 R3 R10 carried reload fires", pin_o, 3);
        tick(base + NSPS + 64'd250);
        chk("R12 pin1 untouched by A", pin_o[1], 1);

        // R11: configuration write cuts the live pulse
        wr(8'h00, 16'h0002);
        chk("R11 cut by config write", pin_o[0], 0);

        // R8: single shot
        wr(8'h00, 16'h0003);
        prog(0, 64'd9 * NSPS, 64'd1000, 16'h0000);
        tick(64'd9 * NSPS);
        chk("R8 first shot", pin_o[0], 1);
        tick(64'd9 * NSPS + 64'd100);
        chk("R8 shot ends", pin_o[0], 0);
        tick(64'd9 * NSPS + 64'd1000);
        chk("R8 no repeat", pin_o[0], 0);
        tick(64'd9 * NSPS + 64'd5000);
        chk("R8 no repeat later", pin_o[0], 0);
        prog(0, 64'd10 * NSPS, 64'd1000, 16'h0000);
        tick(64'd10 * NSPS);
        chk("R8 rearm on target write", pin_o[0], 1);

        // R5/R6: 200 ms code on channel B, active high
        wr(8'h00, 16'h0D08);
        prog(1, 64'd20 * NSPS, NSPS, 16'h0000);
        tick(64'd20 * NSPS);
        chk("R6 B fires", pin_o[1], 1);
        tick(64'd20 * NSPS + 64'd199_999_999);
        chk("R5 200ms still on", pin_o[1], 1);
        tick(64'd20 * NSPS + 64'd200_000_000);
        chk("R5 200ms ends", pin_o[1], 0);

        // R5: reserved code 14 gives 100 ns
        wr(8'h00, 16'h0E08);
        prog(1, 64'd30 * NSPS, NSPS, 16'h0000);
        tick(64'd30 * NSPS);
        chk("R5 code14 on", pin_o[1], 1);
        tick(64'd30 * NSPS + 64'd99);
        chk("R5 code14 still on", pin_o[1], 1);
        tick(64'd30 * NSPS + 64'd100);
        chk("R5 code14 ends", pin_o[1], 0);

        // R9: parked channel A, active high, time just below the park value
        wr(8'h00, 16'h0002);
        prog(0, 64'h0000_0000_FFFF_FFFF * NSPS, 64'd1000, 16'h0000);
        tick(64'd4_294_967_294 * NSPS + 64'd999_999_999);
        chk("R9 parked no pulse", pin_o[0], 0);

        // R3/R5/R6/R7: random trials on both channels at once
        for (int trial = 0; trial < 20; trial++) begin
            int     codes[6];
            int     ca, cb, pa, pb, step;
            longint wa, wb, pera, perb, sa, sb, t;
            codes = '{0, 1, 2, 3, 14, 15};
            ca = codes[$urandom % 6]; cb = codes[$urandom % 6];
            pa = int'($urandom % 2);  pb = int'($urandom % 2);
            wa = w_of(ca); wb = w_of(cb);
            pera = wa + 100 + longint'($urandom % 5000);
            perb = wb + 100 + longint'($urandom % 5000);
            sa = longint'(1 + $urandom % 3) * NSPS + 64'd999_990_000
                 + longint'($urandom % 10000);
            sb = sa + longint'($urandom % 3000);
            step = 1 + int'($urandom % 99);
            tick(0);
            wr(8'h00, 16'(cb << 8) | 16'(ca << 4) | 16'(pb << 3) | 16'(pa << 1));
            prog(0, sa, pera, 16'h0000);
            prog(1, sb, perb, 16'h0000);
            t = sa - 500;
            for (int k = 0; k < 1500; k++) begin
                bit ea, eb;
                tick(t);
                ea = exp_act(t, sa, pera, wa);
                eb = exp_act(t, sb, perb, wb);
                chk("R3 R6 R7 random A", pin_o[0], pa ? ea : !ea);
                chk("R3 R6 R7 random B", pin_o[1], pb ? eb : !eb);
                t = t + step;
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule